// File: doc/BRIEF.md
# Serial Register Access Engine

This block is the register side of a serial converter port. Each transaction in a frame starts with one instruction byte. That byte says whether to read or write, how many data bytes follow (one to four), and the byte address to start at. The engine then shifts the data bytes in or out over a single-bit serial line and steps through the byte addresses. It writes each received byte straight into a small register file. That file holds a data register, a command register, an offset calibration register and a full-scale calibration register.

Two fields of the command register change the shape of later transfers. One reverses the byte order, so a multi-byte access walks the addresses downward. The other makes every data byte travel least-significant bit first. Other command fields act on the registers: one clears the data register, one clears both calibration registers, one picks the data format and one picks the operating mode. The engine also presents the data register as an unsigned level code, so the converter downstream sees one encoding whatever the format.

Top module: `serial_reg_engine`

## Requirements
- R1: After reset the data register, the offset register and the full-scale register are zero. The mode is 2'b10 (sleep), the data format is 0, both order bits are 0, and `sdo_o` is 0.
- R2: The instruction byte is always received most-significant bit first. Bit 7 is 1 for a read, bits 6:5 hold the byte count minus one, and bits 3:0 hold the starting byte address. Every data byte takes effect at the clock edge that carries its eighth `sclk_en_i` strobe.
- R3: Byte addresses are laid out as follows. The data register is at 0 (bits 15:8) and 1 (bits 7:0). The command register is at 4 (high) and 5 (low). The offset register is at 8, 9 and 10 (bits 23:16, 15:8, 7:0). The full-scale register is at 12, 13 and 14 in the same layout. Any other address reads as zero and ignores writes.
- R4: Command-low bit 2 sets the byte order. When it is 0, each further byte of an access goes to the next address up. When it is 1, each further byte goes to the next address down, wrapping modulo 16.
- R5: Command-low bit 3 sets the bit order of the data bytes, in both directions. When it is 0 they move MSB first; when it is 1 they move LSB first.
- R6: A new byte-order or bit-order value applies only from the next instruction. The remaining bytes of the current access keep the order that was latched when its instruction byte completed.
- R7: Writing command-high with bit 6 set zeroes the data register in that same commit. Bit 6 always reads back as 0.
- R8: Writing command-high with bit 7 set zeroes both calibration registers. Bit 7 always reads back as 0.
- R9: Command-high bit 5 selects the data format and reads back. When it is 0 (offset two's complement), `level_o` is the data register with its MSB inverted. When it is 1 (straight binary), `level_o` equals the data register.
- R10: Command-low bits 1:0 hold the mode: 00 normal, 01 self-calibration, 10 sleep. A write of the reserved value 11 leaves the mode unchanged.
- R11: During the data bytes of a read, `sdo_o` presents the bit about to be clocked, in the active bit order, and advances after each strobe. At all other times it is 0. Dropping `frame_i` abandons any partial byte and returns the engine to waiting for an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_i | input | 1 | High while a transfer frame is open |
| sclk_en_i | input | 1 | One-cycle strobe per serial bit |
| sdi_i | input | 1 | Serial data in, sampled on a strobe |
| sdo_o | output | 1 | Serial data out during read bytes |
| data_o | output | 16 | Data register |
| offset_o | output | 24 | Offset calibration register |
| fullscale_o | output | 24 | Full-scale calibration register |
| mode_o | output | 2 | Operating mode |
| dfmt_o | output | 1 | Data format (1 = straight binary) |
| byte_lsbf_o | output | 1 | Configured byte order |
| bit_lsbf_o | output | 1 | Configured bit order |
| level_o | output | 16 | Data register as an unsigned level code |

## Verification
A written byte reaches its register, and any side effect it triggers, at the rising edge that carries its eighth strobe. The bench therefore drives inputs on falling edges and reads register outputs at the falling edge after the closing strobe. A read byte is loaded at the edge that ends the previous byte, so each `sdo_o` bit is sampled on the falling edge just before the strobe that consumes it. A change of order is checked only on the next instruction, apart from one deliberate multi-byte write that changes the order partway through and checks where its last byte landed.

// File: rtl/sre_pkg.sv
`timescale 1ns/1ps
package sre_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;
    localparam int CNT_W  = 2;

    typedef enum logic {PH_INSTR = 1'b0, PH_DATA = 1'b1} phase_e;

    // byte address map
    localparam int DATA_BASE = 0;
    localparam int CMD_HI    = 4;
    localparam int CMD_LO    = 5;
    localparam int OFF_BASE  = 8;
    localparam int FS_BASE   = 12;

    // command high byte fields
    localparam int HI_CALRST = 7;
    localparam int HI_CLR    = 6;
    localparam int HI_DFMT   = 5;
    // command low byte fields
    localparam int LO_BITORD  = 3;
    localparam int LO_BYTEORD = 2;

    localparam logic [1:0] MODE_SLEEP = 2'b10;
    localparam logic [1:0] MODE_RSVD  = 2'b11;

    // instruction byte fields
    localparam int INS_RW     = 7;
    localparam int INS_CNT_LO = 5;
endpackage

// File: rtl/sre_shift.sv
`timescale 1ns/1ps
module sre_shift
    import sre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              sclk_en_i,
    input  logic              sdi_i,
    input  logic              lsb_first_i,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_byte_i,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              sdo_o
);
    localparam int CW = $clog2(BYTE_W);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
    } shift_t;

    shift_t sh_d, sh_q;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        sh_d    = sh_q;
        rx_next = lsb_first_i ? {sdi_i, sh_q.rx[BYTE_W-1:1]}
                              : {sh_q.rx[BYTE_W-2:0], sdi_i};
        byte_o      = rx_next;
        byte_done_o = frame_i && sclk_en_i && (sh_q.cnt == CW'(BYTE_W-1));
        if (!frame_i) begin
            sh_d.cnt = '0;
        end else if (sclk_en_i) begin
            sh_d.cnt = sh_q.cnt + 1'b1;
            sh_d.rx  = rx_next;
            sh_d.tx  = lsb_first_i ? {1'b0, sh_q.tx[BYTE_W-1:1]}
                                   : {sh_q.tx[BYTE_W-2:0], 1'b0};
        end
        if (load_i) sh_d.tx = load_byte_i;
        sdo_o = lsb_first_i ? sh_q.tx[0] : sh_q.tx[BYTE_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    // R2
    bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && sclk_en_i) |=> (sh_q.cnt == $past(sh_q.cnt) + 1'b1));

    // R11
    frame_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> (sh_q.cnt == '0));
endmodule

// File: rtl/sre_ctrl.sv
`timescale 1ns/1ps
module sre_ctrl
    import sre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              byte_done_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              cfg_byte_lsbf_i,
    input  logic              cfg_bit_lsbf_i,
    output logic              shift_lsb_o,
    output logic              load_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              reading_o
);
    typedef struct packed {
        phase_e            phase;
        logic              rw;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] addr;
        logic              act_byte;
        logic              act_bit;
    } ctrl_t;

    ctrl_t ct_d, ct_q;
    logic [ADDR_W-1:0] addr_step;

    always_comb begin
        ct_d      = ct_q;
        addr_step = ct_q.act_byte ? ct_q.addr - 1'b1 : ct_q.addr + 1'b1;
        load_o    = 1'b0;
        wr_en_o   = 1'b0;
        wr_addr_o = ct_q.addr;
        wr_data_o = byte_i;
        rd_addr_o = (ct_q.phase == PH_INSTR) ? byte_i[ADDR_W-1:0] : addr_step;
        if (!frame_i) begin
            ct_d.phase = PH_INSTR;
        end else if (byte_done_i) begin
            if (ct_q.phase == PH_INSTR) begin
                ct_d.phase    = PH_DATA;
                ct_d.rw       = byte_i[INS_RW];
                ct_d.left     = byte_i[INS_CNT_LO +: CNT_W];
                ct_d.addr     = byte_i[ADDR_W-1:0];
                ct_d.act_byte = cfg_byte_lsbf_i;
                ct_d.act_bit  = cfg_bit_lsbf_i;
                load_o        = byte_i[INS_RW];
            end else begin
                wr_en_o = !ct_q.rw;
                if (ct_q.left == '0) begin
                    ct_d.phase = PH_INSTR;
                end else begin
                    ct_d.left = ct_q.left - 1'b1;
                    ct_d.addr = addr_step;
                    load_o    = ct_q.rw;
                end
            end
        end
        shift_lsb_o = (ct_q.phase == PH_DATA) && ct_q.act_bit;
        reading_o   = (ct_q.phase == PH_DATA) && ct_q.rw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ct_q <= '0;
        else        ct_q <= ct_d;
    end

    // R6
    order_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.phase == PH_DATA && $past(ct_q.phase) == PH_DATA)
        |-> ($stable(ct_q.act_byte) && $stable(ct_q.act_bit)));

    // R4
    addr_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_q.phase == PH_DATA && byte_done_i && ct_q.left != '0)
        |=> (ct_q.addr == ($past(ct_q.act_byte) ? $past(ct_q.addr) - 1'b1
                                                : $past(ct_q.addr) + 1'b1)));
endmodule

// File: rtl/sre_regs.sv
`timescale 1ns/1ps
module sre_regs
    import sre_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CAL_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [BYTE_W-1:0] rd_byte_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CAL_W-1:0]  offset_o,
    output logic [CAL_W-1:0]  fullscale_o,
    output logic [1:0]        mode_o,
    output logic              dfmt_o,
    output logic              byte_lsbf_o,
    output logic              bit_lsbf_o,
    output logic [DATA_W-1:0] level_o
);
    localparam int DB = DATA_W / BYTE_W;
    localparam int CB = CAL_W / BYTE_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CAL_W-1:0]  off;
        logic [CAL_W-1:0]  fs;
        logic              dfmt;
        logic              byte_lsbf;
        logic              bit_lsbf;
        logic [1:0]        mode;
    } regs_t;

    localparam regs_t RST_VAL = '{data: '0, off: '0, fs: '0, dfmt: 1'b0,
                                  byte_lsbf: 1'b0, bit_lsbf: 1'b0, mode: MODE_SLEEP};

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en_i) begin
            for (int k = 0; k < DB; k++)
                if (wr_addr_i == ADDR_W'(DATA_BASE + k))
                    rg_d.data[(DB-1-k)*BYTE_W +: BYTE_W] = wr_data_i;
            for (int k = 0; k < CB; k++) begin
                if (wr_addr_i == ADDR_W'(OFF_BASE + k))
                    rg_d.off[(CB-1-k)*BYTE_W +: BYTE_W] = wr_data_i;
                if (wr_addr_i == ADDR_W'(FS_BASE + k))
                    rg_d.fs[(CB-1-k)*BYTE_W +: BYTE_W] = wr_data_i;
            end
            if (wr_addr_i == ADDR_W'(CMD_HI)) begin
                rg_d.dfmt = wr_data_i[HI_DFMT];
                if (wr_data_i[HI_CLR]) rg_d.data = '0;
                if (wr_data_i[HI_CALRST]) begin
                    rg_d.off = '0;
                    rg_d.fs  = '0;
                end
            end
            if (wr_addr_i == ADDR_W'(CMD_LO)) begin
                rg_d.bit_lsbf  = wr_data_i[LO_BITORD];
                rg_d.byte_lsbf = wr_data_i[LO_BYTEORD];
                if (wr_data_i[1:0] != MODE_RSVD) rg_d.mode = wr_data_i[1:0];
            end
        end
    end

    always_comb begin
        rd_byte_o = '0;
        for (int k = 0; k < DB; k++)
            if (rd_addr_i == ADDR_W'(DATA_BASE + k))
                rd_byte_o = rg_q.data[(DB-1-k)*BYTE_W +: BYTE_W];
        for (int k = 0; k < CB; k++) begin
            if (rd_addr_i == ADDR_W'(OFF_BASE + k))
                rd_byte_o = rg_q.off[(CB-1-k)*BYTE_W +: BYTE_W];
            if (rd_addr_i == ADDR_W'(FS_BASE + k))
                rd_byte_o = rg_q.fs[(CB-1-k)*BYTE_W +: BYTE_W];
        end
        if (rd_addr_i == ADDR_W'(CMD_HI)) rd_byte_o[HI_DFMT] = rg_q.dfmt;
        if (rd_addr_i == ADDR_W'(CMD_LO))
            rd_byte_o = {4'b0000, rg_q.bit_lsbf, rg_q.byte_lsbf, rg_q.mode};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= RST_VAL;
        else        rg_q <= rg_d;
    end

    assign data_o      = rg_q.data;
    assign offset_o    = rg_q.off;
    assign fullscale_o = rg_q.fs;
    assign mode_o      = rg_q.mode;
    assign dfmt_o      = rg_q.dfmt;
    assign byte_lsbf_o = rg_q.byte_lsbf;
    assign bit_lsbf_o  = rg_q.bit_lsbf;
    assign level_o     = rg_q.dfmt ? rg_q.data
                                   : {~rg_q.data[DATA_W-1], rg_q.data[DATA_W-2:0]};

    // R7
    clear_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(CMD_HI) && wr_data_i[HI_CLR])
        |=> (rg_q.data == '0));

    // R8
    cal_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(CMD_HI) && wr_data_i[HI_CALRST])
        |=> (rg_q.off == '0 && rg_q.fs == '0));

    // R10
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(CMD_LO) && wr_data_i[1:0] == MODE_RSVD)
        |=> $stable(rg_q.mode));
endmodule

// File: rtl/serial_reg_engine.sv
`timescale 1ns/1ps
module serial_reg_engine
    import sre_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CAL_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              sclk_en_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [DATA_W-1:0] data_o,
    output logic [CAL_W-1:0]  offset_o,
    output logic [CAL_W-1:0]  fullscale_o,
    output logic [1:0]        mode_o,
    output logic              dfmt_o,
    output logic              byte_lsbf_o,
    output logic              bit_lsbf_o,
    output logic [DATA_W-1:0] level_o
);
    logic              byte_done, shift_lsb, load, wr_en, reading, shift_sdo;
    logic [BYTE_W-1:0] byte_val, rd_byte, wr_data;
    logic [ADDR_W-1:0] rd_addr, wr_addr;

    sre_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_i     (frame_i),
        .sclk_en_i   (sclk_en_i),
        .sdi_i       (sdi_i),
        .lsb_first_i (shift_lsb),
        .load_i      (load),
        .load_byte_i (rd_byte),
        .byte_done_o (byte_done),
        .byte_o      (byte_val),
        .sdo_o       (shift_sdo)
    );

    sre_ctrl u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .frame_i         (frame_i),
        .byte_done_i     (byte_done),
        .byte_i          (byte_val),
        .cfg_byte_lsbf_i (byte_lsbf_o),
        .cfg_bit_lsbf_i  (bit_lsbf_o),
        .shift_lsb_o     (shift_lsb),
        .load_o          (load),
        .rd_addr_o       (rd_addr),
        .wr_en_o         (wr_en),
        .wr_addr_o       (wr_addr),
        .wr_data_o       (wr_data),
        .reading_o       (reading)
    );

    sre_regs #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_byte_o   (rd_byte),
        .data_o      (data_o),
        .offset_o    (offset_o),
        .fullscale_o (fullscale_o),
        .mode_o      (mode_o),
        .dfmt_o      (dfmt_o),
        .byte_lsbf_o (byte_lsbf_o),
        .bit_lsbf_o  (bit_lsbf_o),
        .level_o     (level_o)
    );

    assign sdo_o = frame_i && reading && shift_sdo;

    // R11
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reading |-> !sdo_o);
endmodule

// File: tb/serial_reg_engine_test.sv
`timescale 1ns/1ps
module serial_reg_engine_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame = 1'b0, sclk_en = 1'b0, sdi = 1'b0;
    logic sdo_o, dfmt_o, byte_lsbf_o, bit_lsbf_o;
    logic [15:0] data_o, level_o;
    logic [23:0] offset_o, fullscale_o;
    logic [1:0]  mode_o;
    int vec_n = 0, miss_n = 0;
    logic blsb = 1'b0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    serial_reg_engine uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .sclk_en_i(sclk_en), .sdi_i(sdi),
        .sdo_o(sdo_o), .data_o(data_o), .offset_o(offset_o), .fullscale_o(fullscale_o),
        .mode_o(mode_o), .dfmt_o(dfmt_o), .byte_lsbf_o(byte_lsbf_o),
        .bit_lsbf_o(bit_lsbf_o), .level_o(level_o)
    );

    // instr[55:48], write bytes[47:24], expected readback[23:0]
    localparam logic [55:0] VEC [8] = '{
        {8'h20, 24'h123400, 24'h123400},
        {8'h48, 24'hA1B2C3, 24'hA1B2C3},
        {8'h4C, 24'h010203, 24'h010203},
        {8'h22, 24'hFFEE00, 24'h000000},
        {8'h09, 24'h550000, 24'h550000},
        {8'h2E, 24'h776600, 24'h770000},
        {8'h05, 24'h000000, 24'h000000},
        {8'h05, 24'h030000, 24'h000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec_n++;
        if (act !== exp) begin
            miss_n++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic shift_byte(input logic [7:0] v, input logic lsb, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < 8; i++) begin
            int idx;
            idx = lsb ? i : 7 - i;
            @(negedge clk);
            got[idx] = sdo_o;
            sdi      = v[idx];
            sclk_en  = 1'b1;
        end
    endtask

    task automatic xfer(input logic [7:0] ins, input logic [31:0] w, output logic [31:0] r);
        int n;
        logic [7:0] g;
        n = int'(ins[6:5]) + 1;
        r = '0;
        frame = 1'b1;
        shift_byte(ins, 1'b0, g);
        for (int k = 0; k < n; k++) begin
            shift_byte(w[31-8*k -: 8], blsb, g);
            r[31-8*k -: 8] = g;
        end
        @(negedge clk);
        sclk_en = 1'b0;
        frame   = 1'b0;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        miss_n++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] g;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 data", 32'(data_o), 32'h0);
        chk("R1 offset", 32'(offset_o), 32'h0);
        chk("R1 fullscale", 32'(fullscale_o), 32'h0);
        chk("R1 mode", 32'(mode_o), 32'h2);
        chk("R1 orders/fmt/sdo", {28'h0, dfmt_o, byte_lsbf_o, bit_lsbf_o, sdo_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 write then read back each table row
        for (int v = 0; v < 8; v++) begin
            xfer(VEC[v][55:48], {VEC[v][47:24], 8'h00}, rd);
            xfer(VEC[v][55:48] | 8'h80, 32'h0, rd);
            chk($sformatf("R2/R3 row %0d", v), 32'(rd[31:8]), 32'(VEC[v][23:0]));
        end
        chk("R3 data", 32'(data_o), 32'h1234);
        chk("R3 offset", 32'(offset_o), 32'hA155C3);
        chk("R3 fullscale", 32'(fullscale_o), 32'h010277);
        chk("R10 mode after reserved", 32'(mode_o), 32'h0);
        chk("R9 level fmt0", 32'(level_o), 32'h9234);

        // R10 reserved mode ignored
        xfer(8'h05, 32'h01000000, rd);
        chk("R10 mode 01", 32'(mode_o), 32'h1);
        xfer(8'h05, 32'h03000000, rd);
        chk("R10 reserved keeps mode", 32'(mode_o), 32'h1);

        // R9 data format
        xfer(8'h04, 32'h20000000, rd);
        chk("R9 level fmt1", 32'(level_o), 32'h1234);
        xfer(8'h84, 32'h0, rd);
        chk("R9 cmd hi readback", 32'(rd[31:24]), 32'h20);

        // R7 clear
        xfer(8'h04, 32'h60000000, rd);
        chk("R7 data cleared", 32'(data_o), 32'h0);
        chk("R7 level fmt1", 32'(level_o), 32'h0);
        xfer(8'h04, 32'h00000000, rd);
        chk("R7 level fmt0 mid", 32'(level_o), 32'h8000);

        // R8 calibration reset
        xfer(8'h04, 32'h80000000, rd);
        chk("R8 offset", 32'(offset_o), 32'h0);
        chk("R8 fullscale", 32'(fullscale_o), 32'h0);
        xfer(8'hC8, 32'h0, rd);
        chk("R8 offset readback", 32'(rd[31:8]), 32'h0);
        xfer(8'h84, 32'h0, rd);
        chk("R8 R7 action bits read 0", 32'(rd[31:24]), 32'h00);

        // R4 reversed byte order
        xfer(8'h05, 32'h05000000, rd);
        chk("R4 byte order set", 32'(byte_lsbf_o), 32'h1);
        xfer(8'h21, 32'hCDAB0000, rd);
        chk("R4 downward write", 32'(data_o), 32'hABCD);
        xfer(8'hA1, 32'h0, rd);
        chk("R4 downward read", 32'(rd[31:16]), 32'hCDAB);
        xfer(8'hA5, 32'h0, rd);
        chk("R4 read 5 then 4", 32'(rd[31:16]), 32'h0500);
        xfer(8'hA0, 32'h0, rd);
        chk("R4 wrap below zero", 32'(rd[31:16]), 32'hAB00);

        // R6 order change mid-transfer: second byte still goes down to addr 4
        xfer(8'h25, 32'h01200000, rd);
        chk("R6 byte order cleared", 32'(byte_lsbf_o), 32'h0);
        chk("R6 second byte at addr 4", 32'(dfmt_o), 32'h1);

        // R5 bit order
        xfer(8'h05, 32'h09000000, rd);
        chk("R5 bit order set", 32'(bit_lsbf_o), 32'h1);
        blsb = 1'b1;
        xfer(8'h20, 32'h5A3C0000, rd);
        chk("R5 lsb-first write", 32'(data_o), 32'h5A3C);
        xfer(8'hA0, 32'h0, rd);
        chk("R5 lsb-first read", 32'(rd[31:16]), 32'h5A3C);
        xfer(8'h05, 32'h01000000, rd);
        blsb = 1'b0;
        chk("R5 R6 bit order cleared", {30'h0, bit_lsbf_o, mode_o == 2'b01}, 32'h1);
        xfer(8'h80, 32'h0, rd);
        chk("R5 msb-first read", 32'(rd[31:24]), 32'h5A);

        // R11 aborted frame then a clean read
        frame = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            sdi = 1'b1;
            sclk_en = 1'b1;
        end
        @(negedge clk);
        sclk_en = 1'b0;
        frame = 1'b0;
        @(negedge clk);
        chk("R11 sdo idle", 32'(sdo_o), 32'h0);
        xfer(8'h81, 32'h0, rd);
        chk("R11 after abort", 32'(rd[31:24]), 32'h3C);
        g = 8'h0;
        chk("R11 sdo quiet after read", 32'(sdo_o) | 32'(g), 32'h0);

        finish_run();
    end
endmodule